// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single SDR SDRAM device out of power-up and then keeps its contents alive with periodic refresh. After reset it holds the clock enable low and drives no-operation commands. When it receives a start pulse it raises the clock enable and waits for a programmable number of cycles. It then closes every bank with one precharge-all command and issues a configured number of auto-refresh commands. Last, it writes the mode register with a fixed word that carries the configured CAS latency.

Each command waits for the previous one to finish. The gaps come from fixed cycle counts for precharge recovery, refresh cycle time and mode-register settling. After the final settling wait a ready flag rises and stays high. From then on a down-counter pulses a refresh request. Its reload value is the per-row refresh interval in clock cycles, which is the total refresh period shifted right by the row-address width, less a margin of 20 cycles. An outside arbiter consumes the refresh request and schedules the real refresh commands.

Top module: `sdram_init_top`

## Requirements
- R1: After reset, and until a start pulse arrives, the outputs are as follows: cke low, csN low, rasN/casN/weN high (NOP), addr zero, ba zero, ready low, refreshReq low.
- R2: A start pulse acts only in the idle state. A start pulse during the sequence or after ready changes no output.
- R3: cke rises on the clock after start is sampled and then stays high. The precharge-all command is csN/rasN/weN low with casN high and addr bit 10 high. It appears exactly pwrDelay+2 cycles after cke rises.
- R4: Exactly initRefreshes auto-refresh commands are issued. The encoding is csN/rasN/casN low with weN high. The first comes TRP_CYC cycles after the precharge and each following one comes TRC_CYC cycles after the previous one.
- R5: The mode-register load is encoded with csN, rasN, casN and weN all low. It comes TRC_CYC cycles after the last auto-refresh, or TRP_CYC cycles after the precharge when initRefreshes is 0.
- R6: During the mode-register load the address bus carries the following, with ba zero:
  - bits 2:0 = 000 (burst length 1) and bit 3 = 0 (sequential);
  - bits 6:4 = 011 when casLat is 3 and 010 for any other value;
  - bits 8:7 = 00, bit 9 = 1 (single-location writes), and all higher bits 0.
- R7: Every cycle with no precharge, auto-refresh or mode-register load carries NOP with addr zero.
- R8: ready rises exactly TMRD_CYC cycles after the mode-register load. Once high it stays high, and every command from then on is NOP.
- R9: The reload value is rl = (refPeriod >> rowBits) − 20, saturating at 0. refreshReq pulses rl+1 cycles after ready rises and then every rl+1 cycles. It is low in all other cycles.
- R10: rowBits values below 11 act as 11, and values above 13 act as 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts the power-up sequence (used only when idle) |
| casLat | input | 2 | CAS latency, 3 or 2 |
| rowBits | input | 4 | Row-address width, 11 to 13 |
| pwrDelay | input | 16 | Power-up wait in cycles after cke rises |
| initRefreshes | input | 4 | Number of initial auto-refresh commands |
| refPeriod | input | 24 | Total refresh period in clock cycles |
| cke | output | 1 | Clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | 13 | Address bus, carries the mode word |
| ba | output | 2 | Bank address, always zero |
| ready | output | 1 | Initialization done |
| refreshReq | output | 1 | One-cycle periodic refresh request |

## Verification
The hardest case to reach is a stray start pulse that arrives while a wait counter is running or after ready is up. If the design let it act, it would restart the sequence or reload a timer partway, and this shows only as a shifted command several cycles later. The bench injects start in the middle of the power-up wait and just after ready on alternate runs. It compares every cycle with a schedule computed from the configuration. The sweep also covers initRefreshes of zero, out-of-range row widths and a refresh interval below the margin, where the reload saturates to zero and refreshReq pulses on every cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWRUP, S_PRE, S_WAIT_RP, S_AREF, S_WAIT_RC, S_LMR, S_WAIT_MRD, S_READY
  } seqState_e;

  typedef enum logic [1:0] { C_NOP, C_PRE, C_REF, C_LMR } cmdSel_e;

  typedef enum logic [1:0] { W_PWR, W_RP, W_RC, W_MRD } waitSel_e;

  typedef struct packed {
    logic     ckeOn;
    cmdSel_e  cmd;
    logic     loadWait;
    waitSel_e waitSel;
    logic     decWait;
    logic     armRefs;
    logic     decRefs;
    logic     startTimer;
    logic     runTimer;
  } ctrlStrobe_t;

  // {rasN, casN, weN} for each command
  localparam logic [2:0] RCW_NOP = 3'b111;
  localparam logic [2:0] RCW_PRE = 3'b010;
  localparam logic [2:0] RCW_REF = 3'b001;
  localparam logic [2:0] RCW_LMR = 3'b000;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        waitZero,
  input  logic        refsZero,
  output ctrlStrobe_t stb,
  output logic        ready
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.cmd   = C_NOP;
    stb.waitSel = W_PWR;
    unique case (state)
      S_IDLE: if (start) begin
        nextState   = S_PWRUP;
        stb.ckeOn   = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel = W_PWR;
      end
      S_PWRUP: begin
        if (waitZero) nextState = S_PRE;
        else          stb.decWait = 1'b1;
      end
      S_PRE: begin
        stb.cmd      = C_PRE;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_RP;
        stb.armRefs  = 1'b1;
        nextState    = S_WAIT_RP;
      end
      S_WAIT_RP, S_WAIT_RC: begin
        if (waitZero) nextState = refsZero ? S_LMR : S_AREF;
        else          stb.decWait = 1'b1;
      end
      S_AREF: begin
        stb.cmd      = C_REF;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_RC;
        stb.decRefs  = 1'b1;
        nextState    = S_WAIT_RC;
      end
      S_LMR: begin
        stb.cmd      = C_LMR;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_MRD;
        nextState    = S_WAIT_MRD;
      end
      S_WAIT_MRD: begin
        if (waitZero) begin
          nextState      = S_READY;
          stb.startTimer = 1'b1;
        end else begin
          stb.decWait = 1'b1;
        end
      end
      S_READY: stb.runTimer = 1'b1;
      default: nextState = S_IDLE;
    endcase
  end

  assign ready = (state == S_READY);

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int DELAY_W  = 16,
  parameter int CNT_W    = 4,
  parameter int REFP_W   = 24,
  parameter int ADDR_W   = 13,
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 7,
  parameter int TMRD_CYC = 2,
  parameter int MARGIN   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         stb,
  input  logic [1:0]          casLat,
  input  logic [3:0]          rowBits,
  input  logic [DELAY_W-1:0]  pwrDelay,
  input  logic [CNT_W-1:0]    initRefreshes,
  input  logic [REFP_W-1:0]   refPeriod,
  output logic                waitZero,
  output logic                refsZero,
  output logic                cke,
  output logic                csN,
  output logic                rasN,
  output logic                casN,
  output logic                weN,
  output logic [ADDR_W-1:0]   addr,
  output logic [1:0]          ba,
  output logic                refreshReq
);

  localparam logic [DELAY_W-1:0] RP_LOAD  = DELAY_W'(TRP_CYC - 2);
  localparam logic [DELAY_W-1:0] RC_LOAD  = DELAY_W'(TRC_CYC - 2);
  localparam logic [DELAY_W-1:0] MRD_LOAD = DELAY_W'(TMRD_CYC - 1);
  localparam logic [REFP_W-1:0]  MARGIN_V = REFP_W'(MARGIN);
  localparam int                 PRE_BIT  = 10;

  logic [DELAY_W-1:0] waitCnt, waitLoad;
  logic [CNT_W-1:0]   refsLeft;
  logic [REFP_W-1:0]  refTimer, interval, reload;
  logic [3:0]         rowEff;
  logic [2:0]         rcwNext;
  logic [ADDR_W-1:0]  modeWord, addrNext;

  // wait counter shared by all sequence gaps
  always_comb begin
    unique case (stb.waitSel)
      W_PWR:   waitLoad = pwrDelay;
      W_RP:    waitLoad = RP_LOAD;
      W_RC:    waitLoad = RC_LOAD;
      default: waitLoad = MRD_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            waitCnt <= '0;
    else if (stb.loadWait) waitCnt <= waitLoad;
    else if (stb.decWait)  waitCnt <= waitCnt - 1'b1;
  end
  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           refsLeft <= '0;
    else if (stb.armRefs) refsLeft <= initRefreshes;
    else if (stb.decRefs) refsLeft <= refsLeft - 1'b1;
  end
  assign refsZero = (refsLeft == '0);

  // mode word: BL1, sequential, CAS from config, standard, single write
  always_comb begin
    modeWord      = '0;
    modeWord[6:4] = (casLat == 2'd3) ? 3'b011 : 3'b010;
    modeWord[9]   = 1'b1;
  end

  always_comb begin
    addrNext = '0;
    unique case (stb.cmd)
      C_PRE:   begin rcwNext = RCW_PRE; addrNext[PRE_BIT] = 1'b1; end
      C_REF:   rcwNext = RCW_REF;
      C_LMR:   begin rcwNext = RCW_LMR; addrNext = modeWord; end
      default: rcwNext = RCW_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke <= 1'b0;
      {rasN, casN, weN} <= RCW_NOP;
      addr <= '0;
    end else begin
      if (stb.ckeOn) cke <= 1'b1;
      {rasN, casN, weN} <= rcwNext;
      addr <= addrNext;
    end
  end

  assign csN = 1'b0;
  assign ba  = 2'b00;

  // refresh interval timer
  always_comb begin
    if (rowBits < 4'd11)      rowEff = 4'd11;
    else if (rowBits > 4'd13) rowEff = 4'd13;
    else                      rowEff = rowBits;
    interval = refPeriod >> rowEff;
    reload   = (interval > MARGIN_V) ? interval - MARGIN_V : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refTimer   <= '0;
      refreshReq <= 1'b0;
    end else begin
      refreshReq <= 1'b0;
      if (stb.startTimer) begin
        refTimer <= reload;
      end else if (stb.runTimer) begin
        if (refTimer == '0) begin
          refTimer   <= reload;
          refreshReq <= 1'b1;
        end else begin
          refTimer <= refTimer - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_init_top.sv
module sdram_init_top
  import sdram_init_pkg::*;
#(
  parameter int DELAY_W  = 16,
  parameter int CNT_W    = 4,
  parameter int REFP_W   = 24,
  parameter int ADDR_W   = 13,
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 7,
  parameter int TMRD_CYC = 2,
  parameter int MARGIN   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         casLat,
  input  logic [3:0]         rowBits,
  input  logic [DELAY_W-1:0] pwrDelay,
  input  logic [CNT_W-1:0]   initRefreshes,
  input  logic [REFP_W-1:0]  refPeriod,
  output logic               cke,
  output logic               csN,
  output logic               rasN,
  output logic               casN,
  output logic               weN,
  output logic [ADDR_W-1:0]  addr,
  output logic [1:0]         ba,
  output logic               ready,
  output logic               refreshReq
);

  ctrlStrobe_t stb;
  logic        waitZero, refsZero;

  sdram_init_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .waitZero(waitZero), .refsZero(refsZero),
    .stb(stb), .ready(ready)
  );

  sdram_init_dp #(
    .DELAY_W(DELAY_W), .CNT_W(CNT_W), .REFP_W(REFP_W), .ADDR_W(ADDR_W),
    .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .TMRD_CYC(TMRD_CYC), .MARGIN(MARGIN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .casLat(casLat), .rowBits(rowBits), .pwrDelay(pwrDelay),
    .initRefreshes(initRefreshes), .refPeriod(refPeriod),
    .waitZero(waitZero), .refsZero(refsZero),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .ba(ba), .refreshReq(refreshReq)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              refreshReq
);

  // R3
  cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R1
  no_cmd_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ({rasN, casN, weN} == 3'b111 && !ready));

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({rasN, casN, weN} == 3'b010) |-> addr[10]);

  // R6
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({rasN, casN, weN} == 3'b000) |->
      (addr[9] && addr[3:0] == 4'd0 && addr[8:7] == 2'd0 &&
       (addr[6:4] == 3'b010 || addr[6:4] == 3'b011)));

  // R7
  nop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({rasN, casN, weN} == 3'b111) |-> (addr == '0));

  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R8
  quiet_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({rasN, casN, weN} == 3'b111));

  // R9
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refreshReq |-> ready);

endmodule

bind sdram_init_top sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .rasN(rasN), .casN(casN), .weN(weN),
  .addr(addr), .ready(ready), .refreshReq(refreshReq)
);

// File: tb/tb_sdram_init_top.sv
module tb_sdram_init_top;

  localparam int TRP = 3, TRC = 7, TMRD = 2;
  localparam int PER = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  casLat = 2'd2;
  logic [3:0]  rowBits = 4'd11;
  logic [15:0] pwrDelay = '0;
  logic [3:0]  initRefreshes = '0;
  logic [23:0] refPeriod = 24'(PER);
  logic        cke, csN, rasN, casN, weN, ready, refreshReq;
  logic [12:0] addr;
  logic [1:0]  ba;

  int nChecks = 0, nFail = 0;
  int tp, tl, tr, rl, nRef, cfgCas, cfgRb;
  bit poke;

  always #10 clk = ~clk;

  sdram_init_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .casLat(casLat), .rowBits(rowBits),
    .pwrDelay(pwrDelay), .initRefreshes(initRefreshes), .refPeriod(refPeriod),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .ba(ba), .ready(ready), .refreshReq(refreshReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // 0 NOP, 1 PRE, 2 REF, 3 LMR
  function automatic int expKind(input int t);
    if (t == tp) return 1;
    for (int i = 0; i < nRef; i++) if (t == tp + TRP + i * TRC) return 2;
    if (t == tl) return 3;
    return 0;
  endfunction

  task automatic checkCycle(input int t);
    int k, rcw, ea, er;
    string ctag;
    k = (t < 0) ? 0 : expKind(t);
    rcw = (k == 1) ? 2 : (k == 2) ? 1 : (k == 3) ? 0 : 7;
    ea  = (k == 1) ? 1024 : (k == 3) ? (512 + ((cfgCas == 3) ? 48 : 32)) : 0;
    er  = (t > tr && ((t - tr) % (rl + 1)) == 0) ? 1 : 0;
    if (t < 0) ctag = "R1";
    else if (k == 1) ctag = "R3";
    else if (k == 2) ctag = "R4";
    else if (k == 3) ctag = "R5";
    else if (poke) ctag = "R2";
    else ctag = "R7";
    chk(cke == (t >= 0), (t < 0) ? "R1 cke" : "R3 cke", int'(cke), int'(t >= 0));
    chk({csN, rasN, casN, weN} == 4'(rcw), ctag, int'({csN, rasN, casN, weN}), rcw);
    chk(addr == 13'(ea), (k == 3) ? "R6 addr" : "R7 addr", int'(addr), ea);
    chk(ba == 2'd0, "R6 ba", int'(ba), 0);
    chk(ready == (t >= tr), (t < 0) ? "R1 ready" : "R8 ready", int'(ready), int'(t >= tr));
    chk(refreshReq == er[0], (cfgRb < 11 || cfgRb > 13) ? "R10 req" : "R9 req",
        int'(refreshReq), er);
  endtask

  task automatic runOne(input int cas, input int rb, input int d, input int n, input bit pk);
    int rbe, iv, total;
    rst_n = 1'b0; start = 1'b0;
    casLat = 2'(cas); rowBits = 4'(rb); pwrDelay = 16'(d); initRefreshes = 4'(n);
    cfgCas = cas; cfgRb = rb; poke = pk; nRef = n;
    rbe = (rb < 11) ? 11 : (rb > 13) ? 13 : rb;
    iv  = PER >> rbe;
    rl  = (iv > 20) ? iv - 20 : 0;
    tp  = d + 2;
    tl  = tp + TRP + n * TRC;
    tr  = tl + TMRD;
    total = tr + 3 * (rl + 1) + 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin @(negedge clk); checkCycle(-1); end
    start = 1'b1;
    for (int t = 0; t <= total; t++) begin
      @(negedge clk);
      checkCycle(t);
      start = pk && (t == 2 || t == tr + 1);
    end
    start = 1'b0;
  endtask

  initial begin
    int idx = 0;
    // sweep: CAS (1 maps to 2), row width incl. out-of-range (R10), refresh count incl. 0
    for (int c = 1; c <= 3; c++)
      for (int rb = 10; rb <= 14; rb++)
        for (int n = 0; n <= 3; n++)
          for (int d = 0; d <= 5; d += 5) begin
            runOne(c, rb, d, n, idx[0]);
            idx++;
          end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule